// File: doc/BRIEF.md
# NAND Flash Host Register Block

This block gives a processor direct, software-paced control of a raw NAND flash device through eight byte-wide register offsets. One mode byte maps straight onto the flash control pins: command latch, address latch, the active-low chip enable and write protect. Two bits of that same byte steer an external ECC engine. Data bytes travel between the processor and the flash I/O bus through a four-offset data window. Each byte written there is presented on the outgoing bus with a one-cycle write strobe. Each byte read there is captured from the incoming bus with a one-cycle read strobe.

An interrupt status byte and an interrupt mask byte drive a single interrupt line. Bit 7 of the mask acts as a master enable. Every byte written through the data window clears the upper seven status bits and leaves bit 0 as it was. The flash timing and the ECC arithmetic live outside this block. The block only sets the ECC mode levels and issues a one-cycle clear pulse when software selects a mode that restarts the accumulator.

Top module: `nfc_regif`

## Requirements
- R1: After reset the mode, interrupt status and interrupt mask registers are zero. The command latch, address latch and write-protect outputs are low. The chip-enable output `fl_ce_n` is high. `irq`, `ecc_on`, `ecc_dump`, `ecc_clr`, `fl_wr`, `fl_rd` and `reg_rdata` are all zero.
- R2: A write to any of offsets 0x0 to 0x3 drives the written byte onto `fl_dout` and raises `fl_wr` for exactly the one cycle that follows the write.
- R3: A read from any of offsets 0x0 to 0x3 returns, on `reg_rdata` in the following cycle, the byte on `fl_din` during the read cycle, and raises `fl_rd` for that one following cycle.
- R4: Offset 0x4 is the mode register. A write replaces it, and a read returns the last byte written.
- R5: The mode bits drive the flash pins from the cycle after a mode write: bit 0 drives `fl_cle`, bit 1 drives `fl_ale`, bit 7 drives `fl_wp`, and `fl_ce_n` is the inverse of bit 4.
- R6: Mode bits 6:5 select the ECC mode. Code 01 raises `ecc_on`. Code 10 raises `ecc_dump`. Codes 00 and 11 raise neither. Every mode write whose code is 01 or 11 produces a `ecc_clr` pulse exactly one cycle long in the following cycle, and no other write produces one.
- R7: A read of offset 0x5 (status) always returns 0x14.
- R8: Offsets 0x6 (interrupt status) and 0x7 (interrupt mask) are replaced whole by a write and read back the last value written.
- R9: Every write to offsets 0x0 to 0x3 clears interrupt status bits 7:1 and keeps bit 0.
- R10: `irq` is high exactly when mask bit 7 is set and the bitwise AND of mask and status is nonzero. It is re-evaluated in the cycle after any write that changes either register.
- R11: Offsets 0x8 to 0xF are unimplemented. They read as 0x00, and a write to them changes no register, pin, strobe or interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Register offset |
| reg_wdata | input | 8 | Write data byte |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_rd | input | 1 | Read strobe, one cycle per access |
| reg_rdata | output | 8 | Read data byte |
| fl_cle | output | 1 | Flash command latch enable |
| fl_ale | output | 1 | Flash address latch enable |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_wp | output | 1 | Flash write-protect pin level |
| fl_dout | output | 8 | Byte toward the flash I/O bus |
| fl_wr | output | 1 | One-cycle strobe marking a new `fl_dout` byte |
| fl_din | input | 8 | Byte from the flash I/O bus |
| fl_rd | output | 1 | One-cycle strobe marking a byte taken from `fl_din` |
| ecc_on | output | 1 | ECC accumulate mode selected |
| ecc_dump | output | 1 | ECC read-out mode selected |
| ecc_clr | output | 1 | One-cycle ECC accumulator clear |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with a 4-bit offset bus, which puts offsets 0x8 to 0xF within reach as unimplemented space for R11. It also selects registered read data (`RD_PIPE` = 1), so every read result is sampled one cycle after its strobe. With the status constant left at 0x14, the R7 check reads the value the requirement fixes. The interrupt sequences place status bits with and without overlap against the mask, with the master bit both cleared and set. They then use data-window writes to show bit 0 surviving while higher bits vanish.

// File: rtl/nfc_regif_pkg.sv
package nfc_regif_pkg;

   localparam int BYTE_W = 8;
   localparam int OFF_W  = 3;

   localparam logic [OFF_W-1:0] OFF_MODE = 3'd4;
   localparam logic [OFF_W-1:0] OFF_STAT = 3'd5;
   localparam logic [OFF_W-1:0] OFF_ISR  = 3'd6;
   localparam logic [OFF_W-1:0] OFF_IMR  = 3'd7;

   localparam int MB_CLE     = 0;
   localparam int MB_ALE     = 1;
   localparam int MB_CE      = 4;
   localparam int MB_ECC_LSB = 5;
   localparam int MB_WP      = 7;
   localparam int IRQ_MASTER = 7;

   typedef enum logic [1:0] {
      ECC_OFF   = 2'b00,
      ECC_RUN   = 2'b01,
      ECC_DUMP  = 2'b10,
      ECC_CLEAR = 2'b11
   } ecc_code_e;

   typedef struct packed {
      logic data;
      logic mode;
      logic stat;
      logic isr;
      logic imr;
   } nfc_sel_t;

endpackage

// File: rtl/nfc_addr_dec.sv
module nfc_addr_dec
   import nfc_regif_pkg::*;
#(
   parameter int ADDR_W = 4
) (
   input  logic [ADDR_W-1:0] addr,
   output nfc_sel_t          sel
);

   logic             in_page;
   logic [OFF_W-1:0] off;

   assign off = addr[OFF_W-1:0];

   generate
      if (ADDR_W > OFF_W) begin : g_wide
         assign in_page = (addr[ADDR_W-1:OFF_W] == '0);
      end else begin : g_exact
         assign in_page = 1'b1;
      end
   endgenerate

   always_comb begin
      sel      = '0;
      sel.data = in_page && !off[OFF_W-1];
      sel.mode = in_page && (off == OFF_MODE);
      sel.stat = in_page && (off == OFF_STAT);
      sel.isr  = in_page && (off == OFF_ISR);
      sel.imr  = in_page && (off == OFF_IMR);
   end

endmodule

// File: rtl/nfc_mode_ctl.sv
module nfc_mode_ctl
   import nfc_regif_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] mode_q,
   output logic              fl_cle,
   output logic              fl_ale,
   output logic              fl_ce_n,
   output logic              fl_wp,
   output logic              ecc_on,
   output logic              ecc_dump,
   output logic              ecc_clr
);

   ecc_code_e cur_code;
   ecc_code_e new_code;

   assign cur_code = ecc_code_e'(mode_q[MB_ECC_LSB +: 2]);
   assign new_code = ecc_code_e'(wdata[MB_ECC_LSB +: 2]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q  <= '0;
         ecc_clr <= 1'b0;
      end else begin
         ecc_clr <= 1'b0;
         if (wr) begin
            mode_q <= wdata;
            case (new_code)
               ECC_RUN, ECC_CLEAR: ecc_clr <= 1'b1;
               default:            ecc_clr <= 1'b0;
            endcase
         end
      end
   end

   assign fl_cle   = mode_q[MB_CLE];
   assign fl_ale   = mode_q[MB_ALE];
   assign fl_ce_n  = !mode_q[MB_CE];
   assign fl_wp    = mode_q[MB_WP];
   assign ecc_on   = (cur_code == ECC_RUN);
   assign ecc_dump = (cur_code == ECC_DUMP);

endmodule

// File: rtl/nfc_irq_ctl.sv
module nfc_irq_ctl
   import nfc_regif_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_isr,
   input  logic              wr_imr,
   input  logic              wr_data,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] isr_q,
   output logic [BYTE_W-1:0] imr_q,
   output logic              irq
);

   localparam logic [BYTE_W-1:0] KEEP_MASK = BYTE_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         isr_q <= '0;
         imr_q <= '0;
      end else begin
         if (wr_isr) begin
            isr_q <= wdata;
         end else if (wr_data) begin
            isr_q <= isr_q & KEEP_MASK;
         end
         if (wr_imr) begin
            imr_q <= wdata;
         end
      end
   end

   assign irq = imr_q[IRQ_MASTER] && |(imr_q & isr_q);

endmodule

// File: rtl/nfc_rd_path.sv
module nfc_rd_path
   import nfc_regif_pkg::*;
#(
   parameter bit                RD_PIPE    = 1'b1,
   parameter logic [BYTE_W-1:0] STATUS_VAL = 8'h14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd,
   input  nfc_sel_t          sel,
   input  logic [BYTE_W-1:0] mode_q,
   input  logic [BYTE_W-1:0] isr_q,
   input  logic [BYTE_W-1:0] imr_q,
   input  logic [BYTE_W-1:0] fl_din,
   output logic [BYTE_W-1:0] rdata,
   output logic              fl_rd
);

   logic [BYTE_W-1:0] rd_mux;

   always_comb begin
      rd_mux = '0;
      if (sel.data)      rd_mux = fl_din;
      else if (sel.mode) rd_mux = mode_q;
      else if (sel.stat) rd_mux = STATUS_VAL;
      else if (sel.isr)  rd_mux = isr_q;
      else if (sel.imr)  rd_mux = imr_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) fl_rd <= 1'b0;
      else        fl_rd <= rd && sel.data;
   end

   generate
      if (RD_PIPE) begin : g_reg
         logic [BYTE_W-1:0] rdata_q;
         always_ff @(posedge clk) begin
            if (!rst_n)  rdata_q <= '0;
            else if (rd) rdata_q <= rd_mux;
         end
         assign rdata = rdata_q;
      end else begin : g_comb
         assign rdata = rd ? rd_mux : '0;
      end
   endgenerate

endmodule

// File: rtl/nfc_regif.sv
module nfc_regif
   import nfc_regif_pkg::*;
#(
   parameter int                ADDR_W     = 4,
   parameter bit                RD_PIPE    = 1'b1,
   parameter logic [BYTE_W-1:0] STATUS_VAL = 8'h14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [BYTE_W-1:0] reg_wdata,
   input  logic              reg_wr,
   input  logic              reg_rd,
   output logic [BYTE_W-1:0] reg_rdata,
   output logic              fl_cle,
   output logic              fl_ale,
   output logic              fl_ce_n,
   output logic              fl_wp,
   output logic [BYTE_W-1:0] fl_dout,
   output logic              fl_wr,
   input  logic [BYTE_W-1:0] fl_din,
   output logic              fl_rd,
   output logic              ecc_on,
   output logic              ecc_dump,
   output logic              ecc_clr,
   output logic              irq
);

   generate
      if (ADDR_W < OFF_W) begin : g_bad_addr_w
         $error("nfc_regif: ADDR_W must cover the eight register offsets");
      end
   endgenerate

   nfc_sel_t          sel;
   logic              wr_data;
   logic              wr_mode;
   logic              wr_isr;
   logic              wr_imr;
   logic [BYTE_W-1:0] mode_q;
   logic [BYTE_W-1:0] isr_q;
   logic [BYTE_W-1:0] imr_q;

   nfc_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
      .addr (reg_addr),
      .sel  (sel)
   );

   assign wr_data = reg_wr && sel.data;
   assign wr_mode = reg_wr && sel.mode;
   assign wr_isr  = reg_wr && sel.isr;
   assign wr_imr  = reg_wr && sel.imr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fl_dout <= '0;
         fl_wr   <= 1'b0;
      end else begin
         fl_wr <= wr_data;
         if (wr_data) fl_dout <= reg_wdata;
      end
   end

   nfc_mode_ctl u_mode (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (wr_mode),
      .wdata    (reg_wdata),
      .mode_q   (mode_q),
      .fl_cle   (fl_cle),
      .fl_ale   (fl_ale),
      .fl_ce_n  (fl_ce_n),
      .fl_wp    (fl_wp),
      .ecc_on   (ecc_on),
      .ecc_dump (ecc_dump),
      .ecc_clr  (ecc_clr)
   );

   nfc_irq_ctl u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_isr  (wr_isr),
      .wr_imr  (wr_imr),
      .wr_data (wr_data),
      .wdata   (reg_wdata),
      .isr_q   (isr_q),
      .imr_q   (imr_q),
      .irq     (irq)
   );

   nfc_rd_path #(.RD_PIPE(RD_PIPE), .STATUS_VAL(STATUS_VAL)) u_rd (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd     (reg_rd),
      .sel    (sel),
      .mode_q (mode_q),
      .isr_q  (isr_q),
      .imr_q  (imr_q),
      .fl_din (fl_din),
      .rdata  (reg_rdata),
      .fl_rd  (fl_rd)
   );

endmodule

// File: rtl/nfc_regif_chk.sv
module nfc_regif_chk #(
   parameter int       ADDR_W     = 4,
   parameter bit       RD_PIPE    = 1'b1,
   parameter logic [7:0] STATUS_VAL = 8'h14
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [7:0]        reg_wdata,
   input logic              reg_wr,
   input logic              reg_rd,
   input logic [7:0]        reg_rdata,
   input logic              fl_ce_n,
   input logic              fl_wr,
   input logic              ecc_clr,
   input logic              irq,
   input logic [7:0]        mode_q,
   input logic [7:0]        isr_q,
   input logic [7:0]        imr_q
);

   logic [ADDR_W:0] addr_x;
   logic            w_data;
   logic            w_mode;
   logic            w_int;
   logic            w_void;

   assign addr_x = {1'b0, reg_addr};
   assign w_data = reg_wr && (addr_x < (ADDR_W+1)'(4));
   assign w_mode = reg_wr && (addr_x == (ADDR_W+1)'(4));
   assign w_int  = reg_wr && ((addr_x == (ADDR_W+1)'(6)) || (addr_x == (ADDR_W+1)'(7)));
   assign w_void = reg_wr && (addr_x >= (ADDR_W+1)'(8));

   AST_DATA_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      w_data |=> fl_wr);  // R2

   AST_CE_FOLLOWS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      w_mode |=> (fl_ce_n == !$past(reg_wdata[4])));  // R5

   AST_ECC_CLR_ISSUED: assert property (@(posedge clk) disable iff (!rst_n)
      (w_mode && reg_wdata[5]) |=> ecc_clr);  // R6

   AST_ECC_CLR_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
      ecc_clr |-> $past(w_mode && reg_wdata[5]));  // R6

   AST_DATA_WR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      w_data |=> ((isr_q[7:1] == 7'd0) && (isr_q[0] == $past(isr_q[0]))));  // R9

   AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(w_int));  // R10

   AST_VOID_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      w_void |=> ($stable(mode_q) && $stable(isr_q) && $stable(imr_q) && !fl_wr));  // R11

   generate
      if (RD_PIPE) begin : g_stat
         AST_STATUS_CONST: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_rd && (addr_x == (ADDR_W+1)'(5))) |=> (reg_rdata == STATUS_VAL));  // R7
      end
   endgenerate

endmodule

bind nfc_regif nfc_regif_chk #(
   .ADDR_W     (ADDR_W),
   .RD_PIPE    (RD_PIPE),
   .STATUS_VAL (STATUS_VAL)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .reg_wr    (reg_wr),
   .reg_rd    (reg_rd),
   .reg_rdata (reg_rdata),
   .fl_ce_n   (fl_ce_n),
   .fl_wr     (fl_wr),
   .ecc_clr   (ecc_clr),
   .irq       (irq),
   .mode_q    (mode_q),
   .isr_q     (isr_q),
   .imr_q     (imr_q)
);

// File: tb/nfc_regif_bench.sv
module nfc_regif_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic       reg_wr = 1'b0;
   logic       reg_rd = 1'b0;
   logic [7:0] reg_rdata;
   logic       fl_cle, fl_ale, fl_ce_n, fl_wp;
   logic [7:0] fl_dout;
   logic       fl_wr;
   logic [7:0] fl_din = '0;
   logic       fl_rd;
   logic       ecc_on, ecc_dump, ecc_clr, irq;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   nfc_regif #(.ADDR_W(4), .RD_PIPE(1'b1), .STATUS_VAL(8'h14)) u_nfc_regif (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_wr    (reg_wr),
      .reg_rd    (reg_rd),
      .reg_rdata (reg_rdata),
      .fl_cle    (fl_cle),
      .fl_ale    (fl_ale),
      .fl_ce_n   (fl_ce_n),
      .fl_wp     (fl_wp),
      .fl_dout   (fl_dout),
      .fl_wr     (fl_wr),
      .fl_din    (fl_din),
      .fl_rd     (fl_rd),
      .ecc_on    (ecc_on),
      .ecc_dump  (ecc_dump),
      .ecc_clr   (ecc_clr),
      .irq       (irq)
   );

   // {write flag, 3'b0, offset, write data, expected read data}
   localparam int NV = 14;
   localparam logic [23:0] VEC [NV] = '{
      24'h849300,  // mode <= 0x93                       R4
      24'h040093,  // mode reads back                     R4
      24'h86A500,  // status-of-interrupts <= 0xA5        R8
      24'h0600A5,  // reads back                          R8
      24'h873C00,  // mask <= 0x3C                        R8
      24'h07003C,  // reads back                          R8
      24'h050014,  // status constant                     R7
      24'h89FF00,  // write to unimplemented offset       R11
      24'h090000,  // unimplemented reads zero            R11
      24'h0600A5,  // interrupt status untouched          R11
      24'h817700,  // data window write                   R9
      24'h060001,  // only bit 0 survives                 R9
      24'h0F0000,  // top unimplemented offset            R11
      24'h040093   // mode untouched by ignored write     R11
   };

   task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic do_wr(logic [3:0] a, logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic do_rd(logic [3:0] a);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1", "cle", {7'd0, fl_cle}, 8'h00);
      check("R1", "ale", {7'd0, fl_ale}, 8'h00);
      check("R1", "ce_n", {7'd0, fl_ce_n}, 8'h01);
      check("R1", "wp", {7'd0, fl_wp}, 8'h00);
      check("R1", "irq", {7'd0, irq}, 8'h00);
      check("R1", "ecc", {5'd0, ecc_on, ecc_dump, ecc_clr}, 8'h00);
      check("R1", "strobes", {6'd0, fl_wr, fl_rd}, 8'h00);
      check("R1", "rdata", reg_rdata, 8'h00);
      do_rd(4'h4); check("R1", "mode", reg_rdata, 8'h00);
      do_rd(4'h6); check("R1", "isr", reg_rdata, 8'h00);
      do_rd(4'h7); check("R1", "imr", reg_rdata, 8'h00);

      // vector walk: R4 R7 R8 R9 R11
      for (int i = 0; i < NV; i++) begin
         if (VEC[i][23]) begin
            do_wr(VEC[i][19:16], VEC[i][15:8]);
         end else begin
            do_rd(VEC[i][19:16]);
            check("R4/R7/R8/R9/R11", $sformatf("vector %0d", i), reg_rdata, VEC[i][7:0]);
         end
      end

      // R5 pin mapping: mode is 0x93 here
      check("R5", "pins 0x93 {cle,ale,ce_n,wp}", {4'd0, fl_cle, fl_ale, fl_ce_n, fl_wp}, 8'b0000_1101);
      do_wr(4'h4, 8'h10);
      check("R5", "pins 0x10", {4'd0, fl_cle, fl_ale, fl_ce_n, fl_wp}, 8'b0000_0000);
      do_wr(4'h4, 8'h02);
      check("R5", "pins 0x02", {4'd0, fl_cle, fl_ale, fl_ce_n, fl_wp}, 8'b0000_0110);

      // R11 ignored write leaves pins and produces no strobes
      do_wr(4'hC, 8'hFF);
      check("R11", "pins after void write", {4'd0, fl_cle, fl_ale, fl_ce_n, fl_wp}, 8'b0000_0110);
      check("R11", "strobes after void write", {6'd0, fl_wr, ecc_clr}, 8'h00);

      // R6 ECC field {on,dump,clr}
      do_wr(4'h4, 8'h20);
      check("R6", "code 01", {5'd0, ecc_on, ecc_dump, ecc_clr}, 8'b101);
      @(negedge clk);
      check("R6", "code 01 pulse ends", {5'd0, ecc_on, ecc_dump, ecc_clr}, 8'b100);
      do_wr(4'h4, 8'h20);
      check("R6", "code 01 repeated", {5'd0, ecc_on, ecc_dump, ecc_clr}, 8'b101);
      do_wr(4'h4, 8'h60);
      check("R6", "code 11", {5'd0, ecc_on, ecc_dump, ecc_clr}, 8'b001);
      do_wr(4'h4, 8'h40);
      check("R6", "code 10", {5'd0, ecc_on, ecc_dump, ecc_clr}, 8'b010);
      do_wr(4'h4, 8'h00);
      check("R6", "code 00", {5'd0, ecc_on, ecc_dump, ecc_clr}, 8'b000);
      check("R5", "ce_n with zero mode", {7'd0, fl_ce_n}, 8'h01);

      // R2 data window write
      do_wr(4'h2, 8'hC3);
      check("R2", "fl_dout", fl_dout, 8'hC3);
      check("R2", "fl_wr pulse", {7'd0, fl_wr}, 8'h01);
      @(negedge clk);
      check("R2", "fl_wr ends", {7'd0, fl_wr}, 8'h00);

      // R3 data window read
      fl_din = 8'h5A;
      do_rd(4'h3);
      fl_din = 8'hEE;
      check("R3", "rdata from bus", reg_rdata, 8'h5A);
      check("R3", "fl_rd pulse", {7'd0, fl_rd}, 8'h01);
      @(negedge clk);
      check("R3", "fl_rd ends", {7'd0, fl_rd}, 8'h00);

      // R10 interrupt gating
      do_wr(4'h7, 8'h01);
      do_wr(4'h6, 8'h01);
      check("R10", "master off", {7'd0, irq}, 8'h00);
      do_wr(4'h7, 8'h81);
      check("R10", "master on overlap", {7'd0, irq}, 8'h01);
      do_wr(4'h6, 8'h02);
      check("R10", "no overlap", {7'd0, irq}, 8'h00);
      do_wr(4'h7, 8'h82);
      check("R10", "overlap bit1", {7'd0, irq}, 8'h01);
      do_wr(4'h0, 8'h11);
      check("R9", "bit1 cleared drops irq", {7'd0, irq}, 8'h00);
      do_wr(4'h6, 8'h03);
      do_wr(4'h7, 8'h81);
      do_wr(4'h1, 8'h22);
      check("R9", "bit0 kept keeps irq", {7'd0, irq}, 8'h01);
      do_rd(4'h6);
      check("R9", "status after data write", reg_rdata, 8'h01);
      do_wr(4'hE, 8'h00);
      check("R11", "irq after void write", {7'd0, irq}, 8'h01);

      finish_run();
   end

endmodule